// File: doc/BRIEF.md
# Parallel-port slave register bank

This block is the device-side end of an enhanced parallel-port style link. An external bridge acts as master and moves single bytes over a shared 8-bit bidirectional bus. It uses two active-low strobes: one marks an address cycle and the other a data cycle. A direction line says which side drives the bus (low for a master write, high for a master read). The block answers every strobe with a four-phase acknowledge: it raises `ack_o` once it has seen the strobe, and it drops `ack_o` once the master has released the strobe.

An address cycle loads an internal byte pointer. Data cycles then read or write the byte that the pointer selects. The pointer does not advance by itself. The byte space exposes the following virtual I/O to on-chip user logic:

- a version constant;
- an 8-bit LED image and a 24-bit light bar, both read by the host;
- 16 virtual switches and 16 virtual buttons, both written by the host;
- a 32-bit word that the host reads;
- a 32-bit word that the host writes.

Multi-byte fields are little-endian.

The strobes and the direction line are brought into the system clock through two-flop synchronizers. All state changes happen on the clock.

Top module: `ppio_slave`

## Requirements
- R1: After reset, `ack_o` is low and `sw_o`, `btn_o` and `word_o` are all zero.
- R2: After a strobe falls, `ack_o` rises within 4 clock cycles and stays high while that strobe is held low. `ack_o` falls within 4 cycles after both strobes are high again.
- R3: An address cycle with `rd_dir` low loads the byte on the bus into the pointer when the cycle ends. Later data cycles use that pointer.
- R4: A data write loads the addressed host-written byte, and the change appears on the outputs by the time `ack_o` falls. The fields are laid out as follows:
  - `sw_o`: bits 7:0 at address 5 and bits 15:8 at address 6.
  - `btn_o`: bits 7:0 at address 7 and bits 15:8 at address 8.
  - `word_o`: bits 7:0, 15:8, 23:16 and 31:24 at addresses 0x0D, 0x0E, 0x0F and 0x10.
- R5: A data read drives the addressed byte onto the bus while `ack_o` is high. Readable addresses are:
  - address 0: the `VERSION` parameter (default 0xA5);
  - address 1: `led_i`;
  - addresses 2 to 4: `lbar_i`, low byte first;
  - addresses 5 to 8 and 0x0D to 0x10: the stored host-written bytes;
  - addresses 9 to 0x0C: `word_i`, low byte first.
- R6: An address above 0x10 reads as zero. A data write to such an address, or to a read-only address (0 to 4, 9 to 0x0C), changes no output and no stored byte.
- R7: An address cycle with `rd_dir` high is acknowledged but leaves the pointer unchanged.
- R8: The pointer keeps its value across any number of data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adr_stb_n | input | 1 | Address strobe from master, active low |
| dat_stb_n | input | 1 | Data strobe from master, active low |
| rd_dir | input | 1 | Direction: 0 master writes, 1 master reads |
| data_io | inout | 8 | Shared bus; slave drives only while a data read is active |
| ack_o | output | 1 | Handshake acknowledge, active high |
| led_i | input | 8 | LED image readable by host |
| lbar_i | input | 24 | Light-bar image readable by host |
| word_i | input | 32 | Word readable by host |
| sw_o | output | 16 | Virtual switches written by host |
| btn_o | output | 16 | Virtual buttons written by host |
| word_o | output | 32 | Word written by host |

## Verification
Each kind of internal fault shows up at the ports in its own way:

- A corrupted pointer shows on the very next data read as a byte from the wrong field. It can also show as a write landing in the wrong output field, visible as soon as `ack_o` falls.
- A handshake state stuck busy or stuck idle shows as `ack_o` failing to rise or fall within four cycles of the strobe edge. The master then hangs.
- A wrong lane in the byte steering appears as a byte placed in the wrong position of `sw_o`, `btn_o` or `word_o`. It can also appear as a read-back value that differs from the byte written.

// File: rtl/ppio_pkg.sv
`timescale 1ns/1ps
package ppio_pkg;
    localparam int LBAR_BYTES = 3;
    localparam int SW_BYTES   = 2;
    localparam int BTN_BYTES  = 2;
    localparam int WORD_BYTES = 4;

    localparam int ADR_VER   = 0;
    localparam int ADR_LED   = 1;
    localparam int ADR_LBAR  = ADR_LED + 1;
    localparam int ADR_SW    = ADR_LBAR + LBAR_BYTES;
    localparam int ADR_BTN   = ADR_SW + SW_BYTES;
    localparam int ADR_TOH   = ADR_BTN + BTN_BYTES;
    localparam int ADR_FROMH = ADR_TOH + WORD_BYTES;

    typedef enum logic {HS_IDLE = 1'b0, HS_BUSY = 1'b1} hs_state_e;

    typedef struct packed {
        hs_state_e  state;
        logic       is_data;
        logic       is_wr;
        logic [7:0] held;
    } hs_regs_t;

    typedef struct packed {
        logic [7:0]              ptr;
        logic [8*SW_BYTES-1:0]   sw;
        logic [8*BTN_BYTES-1:0]  btn;
        logic [8*WORD_BYTES-1:0] word;
    } bank_regs_t;
endpackage

// File: rtl/ppio_sync.sv
`timescale 1ns/1ps
module ppio_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] IDLE  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) chain_q[s] <= IDLE;
            else        chain_q[s] <= chain_d[s];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ppio_handshake.sv
`timescale 1ns/1ps
module ppio_handshake
    import ppio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       astb_s,
    input  logic       dstb_s,
    input  logic       rd_s,
    input  logic [7:0] bus_i,
    output logic       ack_o,
    output logic       commit_ptr_o,
    output logic       commit_dat_o,
    output logic [7:0] byte_o
);
    hs_regs_t hs_d, hs_q;

    always_comb begin
        hs_d         = hs_q;
        commit_ptr_o = 1'b0;
        commit_dat_o = 1'b0;
        case (hs_q.state)
            HS_IDLE: begin
                if (!astb_s || !dstb_s) begin
                    hs_d.state   = HS_BUSY;
                    hs_d.is_data = !dstb_s;
                    hs_d.is_wr   = !rd_s;
                    hs_d.held    = bus_i;
                end
            end
            default: begin
                if (astb_s && dstb_s) begin
                    hs_d.state   = HS_IDLE;
                    commit_ptr_o = !hs_q.is_data && hs_q.is_wr;
                    commit_dat_o = hs_q.is_data && hs_q.is_wr;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '{state: HS_IDLE, is_data: 1'b0, is_wr: 1'b0, held: 8'h00};
        else        hs_q <= hs_d;
    end

    assign ack_o  = (hs_q.state == HS_BUSY);
    assign byte_o = hs_q.held;

    p_ack_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(!astb_s || !dstb_s));
    p_ack_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(astb_s && dstb_s));
    p_commit_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ptr_o || commit_dat_o) |-> ack_o);
endmodule

// File: rtl/ppio_regbank.sv
`timescale 1ns/1ps
module ppio_regbank
    import ppio_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'hA5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_ptr_i,
    input  logic                      commit_dat_i,
    input  logic [7:0]                wbyte_i,
    input  logic [7:0]                led_i,
    input  logic [8*LBAR_BYTES-1:0]   lbar_i,
    input  logic [8*WORD_BYTES-1:0]   word_i,
    output logic [8*SW_BYTES-1:0]     sw_o,
    output logic [8*BTN_BYTES-1:0]    btn_o,
    output logic [8*WORD_BYTES-1:0]   word_o,
    output logic [7:0]                rbyte_o
);
    bank_regs_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (commit_ptr_i) bk_d.ptr = wbyte_i;
        if (commit_dat_i) begin
            for (int i = 0; i < SW_BYTES; i++)
                if (bk_q.ptr == 8'(ADR_SW + i)) bk_d.sw[8*i +: 8] = wbyte_i;
            for (int i = 0; i < BTN_BYTES; i++)
                if (bk_q.ptr == 8'(ADR_BTN + i)) bk_d.btn[8*i +: 8] = wbyte_i;
            for (int i = 0; i < WORD_BYTES; i++)
                if (bk_q.ptr == 8'(ADR_FROMH + i)) bk_d.word[8*i +: 8] = wbyte_i;
        end
    end

    always_comb begin
        rbyte_o = 8'h00;
        if (bk_q.ptr == 8'(ADR_VER)) rbyte_o = VERSION;
        if (bk_q.ptr == 8'(ADR_LED)) rbyte_o = led_i;
        for (int i = 0; i < LBAR_BYTES; i++)
            if (bk_q.ptr == 8'(ADR_LBAR + i)) rbyte_o = lbar_i[8*i +: 8];
        for (int i = 0; i < SW_BYTES; i++)
            if (bk_q.ptr == 8'(ADR_SW + i)) rbyte_o = bk_q.sw[8*i +: 8];
        for (int i = 0; i < BTN_BYTES; i++)
            if (bk_q.ptr == 8'(ADR_BTN + i)) rbyte_o = bk_q.btn[8*i +: 8];
        for (int i = 0; i < WORD_BYTES; i++)
            if (bk_q.ptr == 8'(ADR_TOH + i)) rbyte_o = word_i[8*i +: 8];
        for (int i = 0; i < WORD_BYTES; i++)
            if (bk_q.ptr == 8'(ADR_FROMH + i)) rbyte_o = bk_q.word[8*i +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign sw_o   = bk_q.sw;
    assign btn_o  = bk_q.btn;
    assign word_o = bk_q.word;

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_ptr_i |=> $stable(bk_q.ptr));
    p_outs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_dat_i |=> $stable({sw_o, btn_o, word_o}));
    p_one_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_ptr_i, commit_dat_i}));
endmodule

// File: rtl/ppio_slave.sv
`timescale 1ns/1ps
module ppio_slave
    import ppio_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'hA5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adr_stb_n,
    input  logic                    dat_stb_n,
    input  logic                    rd_dir,
    inout  wire  [7:0]              data_io,
    output logic                    ack_o,
    input  logic [7:0]              led_i,
    input  logic [8*LBAR_BYTES-1:0] lbar_i,
    input  logic [8*WORD_BYTES-1:0] word_i,
    output logic [8*SW_BYTES-1:0]   sw_o,
    output logic [8*BTN_BYTES-1:0]  btn_o,
    output logic [8*WORD_BYTES-1:0] word_o
);
    logic [2:0] ctl_s;
    logic       commit_ptr, commit_dat;
    logic [7:0] wbyte, rbyte;
    logic       drive_en;

    ppio_sync #(.W(3), .STAGES(2), .IDLE(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({adr_stb_n, dat_stb_n, rd_dir}),
        .sync_o  (ctl_s)
    );

    ppio_handshake u_hs (
        .clk          (clk),
        .rst_n        (rst_n),
        .astb_s       (ctl_s[2]),
        .dstb_s       (ctl_s[1]),
        .rd_s         (ctl_s[0]),
        .bus_i        (data_io),
        .ack_o        (ack_o),
        .commit_ptr_o (commit_ptr),
        .commit_dat_o (commit_dat),
        .byte_o       (wbyte)
    );

    ppio_regbank #(.VERSION(VERSION)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_ptr_i (commit_ptr),
        .commit_dat_i (commit_dat),
        .wbyte_i      (wbyte),
        .led_i        (led_i),
        .lbar_i       (lbar_i),
        .word_i       (word_i),
        .sw_o         (sw_o),
        .btn_o        (btn_o),
        .word_o       (word_o),
        .rbyte_o      (rbyte)
    );

    assign drive_en = !dat_stb_n && rd_dir;
    assign data_io  = drive_en ? rbyte : 8'bz;

    p_no_wr_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_dat |-> !$past(ctl_s[0]));
endmodule

// File: tb/ppio_slave_tb.sv
`timescale 1ns/1ps
module ppio_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        astb_n = 1'b1, dstb_n = 1'b1, rd = 1'b1;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_val = 8'h00;
    wire  [7:0]  bus;
    logic        ack;
    logic [7:0]  led = 8'h00;
    logic [23:0] lbar = 24'h0;
    logic [31:0] wrd_in = 32'h0;
    logic [15:0] sw, btn;
    logic [31:0] wrd_out;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [7:0] VER = 8'hA5;

    always #2 clk = ~clk;
    assign bus = tb_drv ? tb_val : 8'bz;

    ppio_slave u_dut (
        .clk(clk), .rst_n(rst_n), .adr_stb_n(astb_n), .dat_stb_n(dstb_n),
        .rd_dir(rd), .data_io(bus), .ack_o(ack), .led_i(led), .lbar_i(lbar),
        .word_i(wrd_in), .sw_o(sw), .btn_o(btn), .word_o(wrd_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_ack(input logic lvl, input string tag);
        int n = 0;
        while (ack !== lvl && n < 8) begin @(negedge clk); n++; end
        chk({31'b0, ack}, {31'b0, lvl}, tag);
    endtask

    task automatic cycle(input bit is_data, input bit is_rd, input logic [7:0] v);
        @(negedge clk);
        rd = is_rd; tb_drv = !is_rd; tb_val = v;
        if (is_data) dstb_n = 1'b0; else astb_n = 1'b0;
        wait_ack(1'b1, "R2 ack rise");
        repeat (2) @(negedge clk);
        @(negedge clk);
        astb_n = 1'b1; dstb_n = 1'b1;
        wait_ack(1'b0, "R2 ack fall");
        tb_drv = 1'b0; rd = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a); cycle(0, 0, a); endtask
    task automatic wr_byte(input logic [7:0] d); cycle(1, 0, d); endtask
    task automatic rd_byte(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        cycle(1, 1, 8'h00);
    endtask

    // monitor: compare bus during each data read against scoreboard
    initial forever begin
        @(posedge ack);
        @(negedge clk);
        if (!dstb_n && rd) begin
            if (exp_q.size() == 0) chk(32'h1, 32'h0, "R5 unexpected read");
            else begin
                logic [7:0] e; string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                chk({24'h0, bus}, {24'h0, e}, t);
            end
        end
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({31'b0, ack}, 32'h0, "R1 ack after reset");
        chk({sw, btn}, 32'h0, "R1 sw/btn after reset");
        chk(wrd_out, 32'h0, "R1 word after reset");

        led = 8'h3C; lbar = 24'h123456; wrd_in = 32'hCAFEBEEF;
        set_ptr(8'h00); rd_byte(VER, "R5 version");
        set_ptr(8'h01); rd_byte(8'h3C, "R5 led");
        set_ptr(8'h02); rd_byte(8'h56, "R5 lbar low");
        set_ptr(8'h04); rd_byte(8'h12, "R5 lbar high");

        set_ptr(8'h05); wr_byte(8'h9A);
        chk({16'h0, sw}, 32'h009A, "R4 sw low byte");
        set_ptr(8'h06); wr_byte(8'h7E);
        chk({16'h0, sw}, 32'h7E9A, "R4 sw high byte");
        rd_byte(8'h7E, "R8 ptr kept read 1");
        rd_byte(8'h7E, "R8 ptr kept read 2");

        set_ptr(8'h08); wr_byte(8'hF0);
        chk({16'h0, btn}, 32'hF000, "R4 btn high byte");
        for (int i = 0; i < 4; i++) begin
            set_ptr(8'(8'h0D + i)); wr_byte(8'(8'h11 * (i + 1)));
        end
        chk(wrd_out, 32'h44332211, "R4 host word little-endian");
        set_ptr(8'h0F); rd_byte(8'h33, "R5 host word readback");

        set_ptr(8'h09); rd_byte(8'hEF, "R5 to-host low");
        set_ptr(8'h0C); rd_byte(8'hCA, "R5 to-host high");

        set_ptr(8'h20); rd_byte(8'h00, "R6 unmapped reads zero");
        wr_byte(8'h55);
        chk({sw, btn}, 32'h7E9AF000, "R6 unmapped write sw/btn");
        chk(wrd_out, 32'h44332211, "R6 unmapped write word");
        set_ptr(8'h01); wr_byte(8'hAA); rd_byte(8'h3C, "R6 read-only led");
        set_ptr(8'h0A); wr_byte(8'h00); rd_byte(8'hBE, "R6 read-only to-host");

        set_ptr(8'h05);
        cycle(0, 1, 8'h00);
        rd_byte(8'h9A, "R7 address read leaves ptr");
        set_ptr(8'h07); rd_byte(8'h00, "R3 ptr load btn low");

        repeat (4) @(negedge clk);
        chk(exp_q.size(), 0, "R5 all reads observed");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule